// File: doc/BRIEF.md
# Dual-Length Opcode Instruction Decoder

This block decodes a 24-bit instruction word whose opcode is either six or nine bits long. The top six bits decide the length: values below a threshold of 48 are complete short opcodes, and anything at or above it spills three more bits into a nine-bit long opcode. The rest of the word holds a three-bit mode field and then an address field: 15 bits after a short opcode, 12 bits after a long one. Together these fill the word exactly.

The decoder sorts each word into one of seven formats.
- Memory reference with a register destination.
- Memory reference through an index register.
- Plain indirect.
- Pre-indexed indirect.
- A packed pair of register-to-register operations.
- A single-register operate instruction.
- A reserved escape.

Mode `100` would only repeat mode `000`, because index register 0 means "no indexing". The block therefore reuses it to select the extended formats. Eight leading ones in the word escape to single-register operate instructions. The remaining long opcodes with five leading ones are reserved and are reported as illegal.

Each word arrives with a valid strobe. One clock later a registered bundle appears, together with an illegal flag. Fields that do not apply to the chosen format read as zero.

Top module: `insn_dual_decode`

## Requirements
- R1: When word bits [23:18] are below 48, the word is short: opcode = bits [23:18] (zero-extended to 9 bits), mode = bits [17:15], raw address = bits [14:0]. Otherwise the word is long: opcode = bits [23:15], mode = bits [14:12], raw address = bits [11:0] (zero-extended to 15 bits). Mode and opcode are reported for every format.
- R2: When mode bit 2 is 0 (and neither R7 nor R8 applies), the format code is 0 (register destination). The destination is mode[1:0], the index is 0, and the address is the raw address.
- R3: Modes 101, 110 and 111 (when neither R7 nor R8 applies) give format code 1 (indexed). The destination is 0, the index is mode[1:0], and the address is the raw address.
- R4: A short word with mode 100 and bit 14 clear gives format code 2 (packed pair). Slot A = bits [13:7] and slot B = bits [6:0], each slot laid out as {function[2:0], destination[1:0], source[1:0]}. The address, destination and index are 0.
- R5: A short word with mode 100 and bit 14 set gives format code 3 (pre-indexed indirect). The index is bits [13:12] and the address is bits [11:0]. When the index is 0 the word is illegal.
- R6: A long word with mode 100 that is neither operate nor escape gives format code 4 (plain indirect). The address is bits [11:0], and the destination and index are 0.
- R7: A word with bits [23:16] = 8'hFF gives format code 5 (single-register operate). The function is bits [15:8] and the destination is bits [1:0]. The word is illegal when any of bits [7:2] is set.
- R8: A word with bits [23:19] = 5'b11111 but bits [23:16] other than 8'hFF gives format code 6 (escape). It is always illegal, and the address, destination, index, slots and function are all 0.
- R9: The outputs change only on the clock edge after a cycle with in_valid high. out_valid is high for exactly that one cycle, and without in_valid every field holds its value.
- R10: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word strobe |
| in_word | input | 24 | Instruction word |
| out_valid | output | 1 | Bundle updated this cycle |
| out_fmt | output | 3 | Format code |
| out_long | output | 1 | Long opcode word |
| out_opcode | output | 9 | Opcode, zero-extended when short |
| out_mode | output | 3 | Raw mode field |
| out_dest | output | 2 | Destination general register |
| out_index | output | 2 | Index register |
| out_addr | output | 15 | Address or pointer field |
| out_slot_a | output | 7 | First packed register operation |
| out_slot_b | output | 7 | Second packed register operation |
| out_opr_fn | output | 8 | Operate function code |
| out_illegal | output | 1 | Unassigned or reserved pattern |

## Verification
In a single decode, length detection and the prefix escapes act together. An eight-ones prefix is also a long word whose mode bits would otherwise select indirect or indexed decoding, and the escape prefix overlaps the long ordinary range. The stimulus biases words toward these prefixes and toward mode `100`, and adds boundary words at opcode tops 47, 48, 61, 62 and 63. Each result is judged against a bench decode function that applies the precedence operate, then escape, then mode. Strobes alternate with idle cycles, so the hold behaviour is checked right after each overlapping decode.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int WORD_W  = 24;
  localparam int SOP_W   = 6;
  localparam int LOP_W   = 9;
  localparam int MODE_W  = 3;
  localparam int SADDR_W = 15;
  localparam int LADDR_W = 12;
  localparam int REG_W   = 2;
  localparam int SLOT_W  = 7;
  localparam int OPRF_W  = 8;
  localparam int NSLOT   = 2;
  localparam int OPR_PFX_W = 8;
  localparam int ESC_PFX_W = 5;
  localparam int EXT_W   = LOP_W - SOP_W;

  typedef enum logic [2:0] {
    FMT_MREG = 3'd0,
    FMT_MIDX = 3'd1,
    FMT_PAIR = 3'd2,
    FMT_PIND = 3'd3,
    FMT_IND  = 3'd4,
    FMT_OPR  = 3'd5,
    FMT_ESC  = 3'd6
  } fmt_e;

  typedef struct packed {
    fmt_e                  fmt;
    logic                  is_long;
    logic [LOP_W-1:0]      opcode;
    logic [MODE_W-1:0]     mode;
    logic [REG_W-1:0]      dest;
    logic [REG_W-1:0]      index;
    logic [SADDR_W-1:0]    addr;
    logic [SLOT_W-1:0]     slot_a;
    logic [SLOT_W-1:0]     slot_b;
    logic [OPRF_W-1:0]     opr_fn;
    logic                  illegal;
  } dec_t;

  // Length test: top opcode bits at or above the short-opcode count.
  function automatic logic long_form(input logic [WORD_W-1:0] w,
                                     input int unsigned short_ops);
    return 32'(w[WORD_W-1 -: SOP_W]) >= short_ops;
  endfunction

  // Mode 100: index 0 with the index flag set, reused for extended formats.
  function automatic logic ext_code(input logic [MODE_W-1:0] m);
    return m[MODE_W-1] && (m[MODE_W-2:0] == '0);
  endfunction

  function automatic logic all_ones_prefix(input logic [WORD_W-1:0] w,
                                           input int unsigned width);
    logic r;
    r = 1'b1;
    for (int i = 0; i < WORD_W; i++)
      if (i < int'(width) && !w[WORD_W-1-i]) r = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/idec_split.sv
module idec_split
  import idec_pkg::*;
#(
  parameter int unsigned SHORT_OPS = 48
) (
  input  logic [WORD_W-1:0]  word,
  output logic               is_long,
  output logic [LOP_W-1:0]   opcode,
  output logic [MODE_W-1:0]  mode,
  output logic [SADDR_W-1:0] addr
);

  localparam int S_MODE_LO = WORD_W - SOP_W - MODE_W;
  localparam int L_MODE_LO = WORD_W - LOP_W - MODE_W;

  always_comb begin
    is_long = long_form(word, SHORT_OPS);
    if (is_long) begin
      opcode = word[WORD_W-1 -: LOP_W];
      mode   = word[L_MODE_LO +: MODE_W];
      addr   = {{(SADDR_W-LADDR_W){1'b0}}, word[LADDR_W-1:0]};
    end else begin
      opcode = {{EXT_W{1'b0}}, word[WORD_W-1 -: SOP_W]};
      mode   = word[S_MODE_LO +: MODE_W];
      addr   = word[SADDR_W-1:0];
    end
  end

endmodule

// File: rtl/idec_classify.sv
module idec_classify
  import idec_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  input  logic               is_long,
  input  logic [LOP_W-1:0]   opcode,
  input  logic [MODE_W-1:0]  mode,
  input  logic [SADDR_W-1:0] addr,
  output dec_t               dec,
  output logic               opr_hit,
  output logic               esc_hit,
  output logic               ext_hit
);

  localparam int PIND_BIT = SADDR_W - 1;
  localparam int OPR_FN_LO = WORD_W - OPR_PFX_W - OPRF_W;
  localparam int OPR_PAD_W = OPR_FN_LO - REG_W;

  logic [SLOT_W-1:0] slot [NSLOT];

  // Slot 1 is the upper (first) operation, slot 0 the lower one.
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot[s] = word[s*SLOT_W +: SLOT_W];
  end

  logic [OPR_PAD_W-1:0] opr_pad;
  logic [REG_W-1:0]     pind_idx;

  assign opr_hit  = is_long && all_ones_prefix(word, OPR_PFX_W);
  assign esc_hit  = is_long && all_ones_prefix(word, ESC_PFX_W) && !opr_hit;
  assign ext_hit  = ext_code(mode);
  assign opr_pad  = word[REG_W +: OPR_PAD_W];
  assign pind_idx = addr[PIND_BIT-1 -: REG_W];

  always_comb begin
    dec         = '0;
    dec.is_long = is_long;
    dec.opcode  = opcode;
    dec.mode    = mode;
    if (opr_hit) begin
      dec.fmt     = FMT_OPR;
      dec.opr_fn  = word[OPR_FN_LO +: OPRF_W];
      dec.dest    = word[REG_W-1:0];
      dec.illegal = |opr_pad;
    end else if (esc_hit) begin
      dec.fmt     = FMT_ESC;
      dec.illegal = 1'b1;
    end else if (!ext_hit) begin
      dec.addr = addr;
      if (!mode[MODE_W-1]) begin
        dec.fmt  = FMT_MREG;
        dec.dest = mode[REG_W-1:0];
      end else begin
        dec.fmt   = FMT_MIDX;
        dec.index = mode[REG_W-1:0];
      end
    end else if (is_long) begin
      dec.fmt  = FMT_IND;
      dec.addr = addr;
    end else if (!addr[PIND_BIT]) begin
      dec.fmt    = FMT_PAIR;
      dec.slot_a = slot[1];
      dec.slot_b = slot[0];
    end else begin
      dec.fmt     = FMT_PIND;
      dec.index   = pind_idx;
      dec.addr    = {{(SADDR_W-LADDR_W){1'b0}}, addr[LADDR_W-1:0]};
      dec.illegal = (pind_idx == '0);
    end
  end

endmodule

// File: rtl/idec_hold_reg.sv
module idec_hold_reg
  import idec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  dec_t d_in,
  output dec_t q,
  output logic q_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= cap_en;
      if (cap_en) q <= d_in;
    end
  end

endmodule

// File: rtl/insn_dual_decode.sv
module insn_dual_decode
  import idec_pkg::*;
#(
  parameter int unsigned SHORT_OPS = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [WORD_W-1:0]    in_word,
  output logic                 out_valid,
  output logic [2:0]           out_fmt,
  output logic                 out_long,
  output logic [LOP_W-1:0]     out_opcode,
  output logic [MODE_W-1:0]    out_mode,
  output logic [REG_W-1:0]     out_dest,
  output logic [REG_W-1:0]     out_index,
  output logic [SADDR_W-1:0]   out_addr,
  output logic [SLOT_W-1:0]    out_slot_a,
  output logic [SLOT_W-1:0]    out_slot_b,
  output logic [OPRF_W-1:0]    out_opr_fn,
  output logic                 out_illegal
);

  logic               w_long;
  logic [LOP_W-1:0]   w_opcode;
  logic [MODE_W-1:0]  w_mode;
  logic [SADDR_W-1:0] w_addr;
  dec_t               w_dec;
  dec_t               r_dec;
  logic               w_opr_hit;
  logic               w_esc_hit;
  logic               w_ext_hit;

  idec_split #(.SHORT_OPS(SHORT_OPS)) split_i (
    .word    (in_word),
    .is_long (w_long),
    .opcode  (w_opcode),
    .mode    (w_mode),
    .addr    (w_addr)
  );

  idec_classify class_i (
    .word    (in_word),
    .is_long (w_long),
    .opcode  (w_opcode),
    .mode    (w_mode),
    .addr    (w_addr),
    .dec     (w_dec),
    .opr_hit (w_opr_hit),
    .esc_hit (w_esc_hit),
    .ext_hit (w_ext_hit)
  );

  idec_hold_reg hold_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (in_valid),
    .d_in    (w_dec),
    .q       (r_dec),
    .q_valid (out_valid)
  );

  assign out_fmt     = r_dec.fmt;
  assign out_long    = r_dec.is_long;
  assign out_opcode  = r_dec.opcode;
  assign out_mode    = r_dec.mode;
  assign out_dest    = r_dec.dest;
  assign out_index   = r_dec.index;
  assign out_addr    = r_dec.addr;
  assign out_slot_a  = r_dec.slot_a;
  assign out_slot_b  = r_dec.slot_b;
  assign out_opr_fn  = r_dec.opr_fn;
  assign out_illegal = r_dec.illegal;

endmodule

// File: rtl/idec_checker.sv
module idec_checker
  import idec_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               esc_hit,
  input logic               opr_hit,
  input logic               ext_hit,
  input logic               out_valid,
  input logic [2:0]         out_fmt,
  input logic               out_long,
  input logic [LOP_W-1:0]   out_opcode,
  input logic [MODE_W-1:0]  out_mode,
  input logic [REG_W-1:0]   out_dest,
  input logic [REG_W-1:0]   out_index,
  input logic [SADDR_W-1:0] out_addr,
  input logic               out_illegal
);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable({out_fmt, out_opcode, out_addr, out_illegal})));

  a_r1_short_range: assert property (@(posedge clk) disable iff (!rst_n)
    !out_long |-> (out_opcode < 9'd48));

  a_r3_index_used: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fmt == FMT_MIDX) |-> (out_index != '0 && out_dest == '0));

  a_r4_pair_short: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fmt == FMT_PAIR) |-> (!out_long && out_mode == 3'b100 && out_addr == '0));

  a_r6_ind_long: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fmt == FMT_IND) |-> (out_long && out_index == '0 && !out_illegal));

  a_r7_opr_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fmt == FMT_OPR) |-> (out_long && out_opcode[LOP_W-1:1] == 8'hFF));

  a_r8_esc_event: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && esc_hit) |=> (out_fmt == FMT_ESC && out_illegal));

  a_r7_opr_event: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opr_hit) |=> (out_fmt == FMT_OPR));

  a_r5_ext_event: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ext_hit && !esc_hit && !opr_hit) |=>
      (out_fmt == FMT_PAIR || out_fmt == FMT_PIND || out_fmt == FMT_IND));

endmodule

bind insn_dual_decode idec_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .esc_hit     (w_esc_hit),
  .opr_hit     (w_opr_hit),
  .ext_hit     (w_ext_hit),
  .out_valid   (out_valid),
  .out_fmt     (out_fmt),
  .out_long    (out_long),
  .out_opcode  (out_opcode),
  .out_mode    (out_mode),
  .out_dest    (out_dest),
  .out_index   (out_index),
  .out_addr    (out_addr),
  .out_illegal (out_illegal)
);

// File: tb/insn_dual_decode_tb_top.sv
`timescale 1ns/1ps
module insn_dual_decode_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_word = '0;
  logic        out_valid;
  logic [2:0]  out_fmt;
  logic        out_long;
  logic [8:0]  out_opcode;
  logic [2:0]  out_mode;
  logic [1:0]  out_dest;
  logic [1:0]  out_index;
  logic [14:0] out_addr;
  logic [6:0]  out_slot_a;
  logic [6:0]  out_slot_b;
  logic [7:0]  out_opr_fn;
  logic        out_illegal;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [57:0] last_exp = '0;

  always #5 clk = ~clk;

  insn_dual_decode dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_fmt(out_fmt), .out_long(out_long),
    .out_opcode(out_opcode), .out_mode(out_mode), .out_dest(out_dest),
    .out_index(out_index), .out_addr(out_addr), .out_slot_a(out_slot_a),
    .out_slot_b(out_slot_b), .out_opr_fn(out_opr_fn), .out_illegal(out_illegal)
  );

  function automatic logic [57:0] observed();
    return {out_fmt, out_long, out_opcode, out_mode, out_dest, out_index,
            out_addr, out_slot_a, out_slot_b, out_opr_fn, out_illegal};
  endfunction

  // Independent restatement of R1..R8 as one packed result.
  function automatic logic [57:0] model(input logic [23:0] w);
    logic [2:0] f; logic lg; logic [8:0] op; logic [2:0] md;
    logic [1:0] de, ix; logic [14:0] ad, raw; logic [6:0] sa, sb;
    logic [7:0] fn; logic il;
    f = 3'd0; de = 0; ix = 0; ad = 0; sa = 0; sb = 0; fn = 0; il = 0;
    lg = (w >> 18) >= 24'd48;
    if (lg) begin
      op = 9'(w >> 15); md = 3'((w >> 12) & 7); raw = 15'(w & 24'hFFF);
    end else begin
      op = 9'(w >> 18); md = 3'((w >> 15) & 7); raw = 15'(w & 24'h7FFF);
    end
    if ((w >> 16) == 24'hFF) begin
      f = 3'd5; fn = 8'((w >> 8) & 8'hFF); de = 2'(w & 3); il = ((w & 24'hFC) != 0);
    end else if ((w >> 19) == 24'h1F) begin
      f = 3'd6; il = 1'b1;
    end else if (md != 3'b100) begin
      ad = raw;
      if (md < 3'd4) begin f = 3'd0; de = md[1:0]; end
      else begin f = 3'd1; ix = md[1:0]; end
    end else if (lg) begin
      f = 3'd4; ad = raw;
    end else if (raw < 15'h4000) begin
      f = 3'd2; sa = 7'((w >> 7) & 7'h7F); sb = 7'(w & 7'h7F);
    end else begin
      f = 3'd3; ix = 2'((w >> 12) & 3); ad = 15'(w & 24'hFFF); il = (ix == 2'd0);
    end
    return {f, lg, op, md, de, ix, ad, sa, sb, fn, il};
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_vec(input string tag, input logic [57:0] act, input logic [57:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive at negedge, capture at posedge, judge at the following negedge.
  task automatic apply(input logic [23:0] w);
    logic [57:0] e;
    e = model(w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R9 valid", out_valid, 1'b1);
    check_vec($sformatf("R1,%s word=%h", tag_of(e[57:55]), w), observed(), e);
    last_exp = e;
  endtask

  task automatic idle(input logic [23:0] w);
    in_valid = 1'b0;
    in_word  = w;
    @(negedge clk);
    check_bit("R9 idle valid", out_valid, 1'b0);
    check_vec("R9 hold", observed(), last_exp);
  endtask

  function automatic logic [23:0] pick_word();
    logic [23:0] w;
    w = 24'($urandom);
    case ($urandom % 5)
      0: ;
      1: w[23:16] = 8'hFF;
      2: w[23:19] = 5'h1F;
      3: begin w[23:18] = 6'($urandom % 48); w[17:15] = 3'b100; end
      default: begin w[23:18] = 6'd48 + 6'($urandom % 14); w[14:12] = 3'b100; end
    endcase
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    check_bit("R10 valid in reset", out_valid, 1'b0);
    check_vec("R10 bundle in reset", observed(), '0);
    rst_n = 1'b1;
    @(negedge clk);

    apply({6'd5, 3'b010, 15'h1234});            // R2 short register
    apply({6'd47, 3'b111, 15'h7FFF});           // R3 boundary short
    idle(24'hFFFFFF);                           // R9 ignore
    apply({6'd48, 3'b001, 3'b000, 12'hABC});    // R1 first long, R2
    apply({6'd61, 3'b111, 3'b110, 12'h00F});    // R3 long indexed
    apply({6'd50, 3'b010, 3'b100, 12'h345});    // R6 plain indirect
    apply({6'd9, 3'b100, 1'b0, 7'h5A, 7'h27});  // R4 pair
    apply({6'd9, 3'b100, 1'b1, 2'd2, 12'h777}); // R5 pre-indexed
    apply({6'd9, 3'b100, 1'b1, 2'd0, 12'h777}); // R5 index 0 illegal
    apply(24'hFFA503);                          // R7 legal operate
    apply(24'hFFA5F3);                          // R7 pad bits set
    idle(24'hF80000);
    apply(24'hF80000);                          // R8 escape low
    apply(24'hFE1234);                          // R8 escape high
    apply(24'hFC4000);                          // R8 escape, mode 100

    for (int i = 0; i < 3000; i++) begin
      apply(pick_word());
      if ($urandom % 3 == 0) idle(24'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule